// File: doc/BRIEF.md
# Serial Flash Reset Command Decoder

This block sits on the device side of a serial flash interface. It watches the chip-select, serial clock and serial data pins and oversamples them with the core clock. It assembles one opcode from each chip-select frame. Its job is the two-step software reset. First, a complete enable frame (0x66) arms the block. A reset frame (0x99) in the very next frame then fires it. When that happens, the block returns a bank of volatile device settings to their power-on values. It also sends a one-cycle abort pulse to any internal operation that is running, and holds a busy flag for a fixed recovery interval. During that interval every frame is ignored.

The volatile settings are owned by this block and exposed as outputs. The rest of the device writes new values into them through a plain update port: `upd_valid` plus one field per setting. That port has no back-pressure. An update offered while busy is simply dropped. The asynchronous power-on reset applies the same defaults. Pins are treated as asynchronous. Each SCLK high and low phase must last at least three core clock periods, and SI must be stable for that long around the SCLK rising edge.

Top module: `flash_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it, all volatile outputs hold their parameter defaults, and `busy` and `abort_pulse` are 0.
- R2: When not busy, an `upd_valid` cycle loads every update field into the matching output on the next clock.
- R3: A reset frame (0x99, exactly 8 bits, MSB first, SI sampled on SCLK rising edges) whose immediately preceding frame was a complete 0x66 frame is accepted. On acceptance `abort_pulse` is high for exactly one clock, every volatile output returns to its default in that same cycle, and `busy` rises in that same cycle. A repeated 0x66 keeps the block armed.
- R4: A 0x99 frame without a preceding enable frame has no effect on any output.
- R5: Any other complete 8-bit opcode between the enable and the reset frame disarms the block, so the following 0x99 is not accepted.
- R6: A frame whose SCLK rising-edge count is not exactly 8 (for example 7, 9 or 16) is not an opcode frame. It disarms the block, even when its first 8 bits read 0x99.
- R7: A chip-select pulse with no SCLK rising edge is not a frame and leaves the armed state unchanged.
- R8: After acceptance, `busy` stays high for exactly LOCK_CYCLES clock cycles.
- R9: While busy, every frame is ignored, including an enable/reset pair and any arming. Update cycles are ignored too. Acceptance clears the armed state, so a lone 0x99 after the lockout is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| upd_valid | input | 1 | Load the update fields this cycle |
| upd_status | input | STAT_W | New volatile status bits |
| upd_wel | input | 1 | New write enable latch |
| upd_sus | input | 1 | New program/erase suspend flag |
| upd_rdparam | input | PARM_W | New read parameter byte |
| upd_cmode | input | MODE_W | New continuous read mode byte |
| upd_wrap | input | WRAP_W | New wrap setting |
| busy | output | 1 | High during reset recovery lockout |
| abort_pulse | output | 1 | One-cycle abort for internal operations |
| st_status | output | STAT_W | Volatile status bits |
| st_wel | output | 1 | Write enable latch |
| st_sus | output | 1 | Program/erase suspend flag |
| st_rdparam | output | PARM_W | Read parameter byte |
| st_cmode | output | MODE_W | Continuous read mode byte |
| st_wrap | output | WRAP_W | Wrap setting |

## Verification
The hardest case to reach from the pins is a frame that arrives while the lockout runs, and in particular a well-formed enable/reset pair that must fail to re-trigger. The bench shortens the lockout through its parameter. It then sends two full frames back to back while `busy` is still high, and offers an update in the same window. After `busy` falls, a lone 0x99 shows whether any arming leaked through. Malformed frames of 7, 9 and 16 bits, and a chip-select pulse with no clock, are placed between an enable and a reset to probe the disarm rules.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

  localparam int OP_BITS = 8;
  localparam logic [OP_BITS-1:0] OP_ARM  = 8'h66;
  localparam logic [OP_BITS-1:0] OP_FIRE = 8'h99;

  typedef enum logic [1:0] {
    FRM_NONE  = 2'd0,
    FRM_ARM   = 2'd1,
    FRM_FIRE  = 2'd2,
    FRM_OTHER = 2'd3
  } frame_kind_t;

  function automatic frame_kind_t classify(input logic empty, input logic len_ok,
                                           input logic [OP_BITS-1:0] op);
    if (empty)             return FRM_NONE;
    else if (!len_ok)      return FRM_OTHER;
    else if (op == OP_ARM) return FRM_ARM;
    else if (op == OP_FIRE) return FRM_FIRE;
    else                   return FRM_OTHER;
  endfunction

endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/flash_frame_rx.sv
module flash_frame_rx
  import flash_rst_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_s,
  input  logic               sclk_s,
  input  logic               si_s,
  output logic               frame_end,
  output frame_kind_t        frame_kind
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_OP  = CNT_W'(OP_BITS);

  logic               cs_q, sclk_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic [OP_BITS-1:0] shreg;
  logic               sclk_rise;

  assign sclk_rise = sclk_s && !sclk_q;
  assign frame_end = cs_s && !cs_q;
  assign frame_kind = classify(bit_cnt == '0, bit_cnt == CNT_OP, shreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (cs_s) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (sclk_rise) begin
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      shreg <= {shreg[OP_BITS-2:0], si_s};
    end
  end
endmodule

// File: rtl/flash_reset_seq.sv
module flash_reset_seq
  import flash_rst_pkg::*;
#(
  parameter int LOCK_CYCLES = 12000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_end,
  input  frame_kind_t frame_kind,
  output logic        fire,
  output logic        busy,
  output logic        abort_pulse
);
  localparam int LCW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LCW-1:0] LOAD = LCW'(LOCK_CYCLES - 1);

  logic           armed;
  logic [LCW-1:0] remain;
  logic           take;

  assign take = frame_end && !busy && (frame_kind != FRM_NONE);
  assign fire = take && armed && (frame_kind == FRM_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (take) armed <= (frame_kind == FRM_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      remain      <= '0;
      abort_pulse <= 1'b0;
    end else begin
      abort_pulse <= fire;
      if (fire) begin
        busy   <= 1'b1;
        remain <= LOAD;
      end else if (busy) begin
        if (remain == '0) busy <= 1'b0;
        else              remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_vol_regs.sv
module flash_vol_regs #(
  parameter int STAT_W = 8,
  parameter int PARM_W = 8,
  parameter int MODE_W = 8,
  parameter int WRAP_W = 3,
  parameter logic [STAT_W-1:0] DEF_STATUS  = '0,
  parameter logic              DEF_WEL     = 1'b0,
  parameter logic              DEF_SUS     = 1'b0,
  parameter logic [PARM_W-1:0] DEF_RDPARAM = '0,
  parameter logic [MODE_W-1:0] DEF_CMODE   = '0,
  parameter logic [WRAP_W-1:0] DEF_WRAP    = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              lock,
  input  logic              upd_valid,
  input  logic [STAT_W-1:0] upd_status,
  input  logic              upd_wel,
  input  logic              upd_sus,
  input  logic [PARM_W-1:0] upd_rdparam,
  input  logic [MODE_W-1:0] upd_cmode,
  input  logic [WRAP_W-1:0] upd_wrap,
  output logic [STAT_W-1:0] st_status,
  output logic              st_wel,
  output logic              st_sus,
  output logic [PARM_W-1:0] st_rdparam,
  output logic [MODE_W-1:0] st_cmode,
  output logic [WRAP_W-1:0] st_wrap
);
  logic load;
  assign load = upd_valid && !lock && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_status  <= DEF_STATUS;
      st_wel     <= DEF_WEL;
      st_sus     <= DEF_SUS;
      st_rdparam <= DEF_RDPARAM;
      st_cmode   <= DEF_CMODE;
      st_wrap    <= DEF_WRAP;
    end else if (clear) begin
      st_status  <= DEF_STATUS;
      st_wel     <= DEF_WEL;
      st_sus     <= DEF_SUS;
      st_rdparam <= DEF_RDPARAM;
      st_cmode   <= DEF_CMODE;
      st_wrap    <= DEF_WRAP;
    end else if (load) begin
      st_status  <= upd_status;
      st_wel     <= upd_wel;
      st_sus     <= upd_sus;
      st_rdparam <= upd_rdparam;
      st_cmode   <= upd_cmode;
      st_wrap    <= upd_wrap;
    end
  end
endmodule

// File: rtl/flash_reset_ctrl.sv
module flash_reset_ctrl
  import flash_rst_pkg::*;
#(
  parameter int STAT_W      = 8,
  parameter int PARM_W      = 8,
  parameter int MODE_W      = 8,
  parameter int WRAP_W      = 3,
  parameter int LOCK_CYCLES = 12000,
  parameter int SYNC_STAGES = 2,
  parameter logic [STAT_W-1:0] DEF_STATUS  = '0,
  parameter logic              DEF_WEL     = 1'b0,
  parameter logic              DEF_SUS     = 1'b0,
  parameter logic [PARM_W-1:0] DEF_RDPARAM = '0,
  parameter logic [MODE_W-1:0] DEF_CMODE   = '0,
  parameter logic [WRAP_W-1:0] DEF_WRAP    = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              si,
  input  logic              upd_valid,
  input  logic [STAT_W-1:0] upd_status,
  input  logic              upd_wel,
  input  logic              upd_sus,
  input  logic [PARM_W-1:0] upd_rdparam,
  input  logic [MODE_W-1:0] upd_cmode,
  input  logic [WRAP_W-1:0] upd_wrap,
  output logic              busy,
  output logic              abort_pulse,
  output logic [STAT_W-1:0] st_status,
  output logic              st_wel,
  output logic              st_sus,
  output logic [PARM_W-1:0] st_rdparam,
  output logic [MODE_W-1:0] st_cmode,
  output logic [WRAP_W-1:0] st_wrap
);
  localparam int CNT_W = $clog2(OP_BITS + 2);

  logic [2:0]  pins_s;
  logic        frame_end;
  frame_kind_t frame_kind;
  logic        fire;

  flash_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, si}), .q(pins_s)
  );

  flash_frame_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .si_s(pins_s[0]),
    .frame_end(frame_end), .frame_kind(frame_kind)
  );

  flash_reset_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_kind(frame_kind),
    .fire(fire), .busy(busy), .abort_pulse(abort_pulse)
  );

  flash_vol_regs #(
    .STAT_W(STAT_W), .PARM_W(PARM_W), .MODE_W(MODE_W), .WRAP_W(WRAP_W),
    .DEF_STATUS(DEF_STATUS), .DEF_WEL(DEF_WEL), .DEF_SUS(DEF_SUS),
    .DEF_RDPARAM(DEF_RDPARAM), .DEF_CMODE(DEF_CMODE), .DEF_WRAP(DEF_WRAP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .clear(fire), .lock(busy),
    .upd_valid(upd_valid), .upd_status(upd_status), .upd_wel(upd_wel),
    .upd_sus(upd_sus), .upd_rdparam(upd_rdparam), .upd_cmode(upd_cmode),
    .upd_wrap(upd_wrap),
    .st_status(st_status), .st_wel(st_wel), .st_sus(st_sus),
    .st_rdparam(st_rdparam), .st_cmode(st_cmode), .st_wrap(st_wrap)
  );
endmodule

// File: rtl/flash_reset_ctrl_chk.sv
module flash_reset_ctrl_chk #(
  parameter int STAT_W = 8,
  parameter int PARM_W = 8,
  parameter int MODE_W = 8,
  parameter int WRAP_W = 3,
  parameter int LOCK_CYCLES = 12000,
  parameter logic [STAT_W-1:0] DEF_STATUS  = '0,
  parameter logic              DEF_WEL     = 1'b0,
  parameter logic              DEF_SUS     = 1'b0,
  parameter logic [PARM_W-1:0] DEF_RDPARAM = '0,
  parameter logic [MODE_W-1:0] DEF_CMODE   = '0,
  parameter logic [WRAP_W-1:0] DEF_WRAP    = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              abort_pulse,
  input logic [STAT_W-1:0] st_status,
  input logic              st_wel,
  input logic              st_sus,
  input logic [PARM_W-1:0] st_rdparam,
  input logic [MODE_W-1:0] st_cmode,
  input logic [WRAP_W-1:0] st_wrap
);
  localparam int RW = $clog2(LOCK_CYCLES + 2);
  logic [RW-1:0] run;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy;
      run    <= busy ? run + 1'b1 : '0;
    end
  end

  AST_RST_IDLE: assert property (@(posedge clk) !rst_n |-> !busy && !abort_pulse); // R1
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse); // R3
  AST_ABORT_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> busy && !busy_q); // R3
  AST_BUSY_STARTS_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_q) |-> abort_pulse); // R3
  AST_DEFAULTS_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (st_status == DEF_STATUS && st_wel == DEF_WEL && st_sus == DEF_SUS &&
                     st_rdparam == DEF_RDPARAM && st_cmode == DEF_CMODE &&
                     st_wrap == DEF_WRAP)); // R3
  AST_LOCK_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && busy_q) |-> run == RW'(LOCK_CYCLES)); // R8
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_q) |-> ($stable(st_status) && $stable(st_wel) && $stable(st_sus) &&
                          $stable(st_rdparam) && $stable(st_cmode) && $stable(st_wrap))); // R9
endmodule

bind flash_reset_ctrl flash_reset_ctrl_chk #(
  .STAT_W(STAT_W), .PARM_W(PARM_W), .MODE_W(MODE_W), .WRAP_W(WRAP_W),
  .LOCK_CYCLES(LOCK_CYCLES),
  .DEF_STATUS(DEF_STATUS), .DEF_WEL(DEF_WEL), .DEF_SUS(DEF_SUS),
  .DEF_RDPARAM(DEF_RDPARAM), .DEF_CMODE(DEF_CMODE), .DEF_WRAP(DEF_WRAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .abort_pulse(abort_pulse),
  .st_status(st_status), .st_wel(st_wel), .st_sus(st_sus),
  .st_rdparam(st_rdparam), .st_cmode(st_cmode), .st_wrap(st_wrap)
);

// File: tb/flash_reset_ctrl_test.sv
`timescale 1ns/1ps
module flash_reset_ctrl_test;
  localparam int LOCK = 300;
  localparam logic [7:0] D_STAT = 8'h40, D_RP = 8'h00, D_CM = 8'hFF;
  localparam logic [2:0] D_WRAP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  logic upd_valid = 1'b0, upd_wel = 1'b0, upd_sus = 1'b0;
  logic [7:0] upd_status = '0, upd_rdparam = '0, upd_cmode = '0;
  logic [2:0] upd_wrap = '0;
  logic busy, abort_pulse, st_wel, st_sus;
  logic [7:0] st_status, st_rdparam, st_cmode;
  logic [2:0] st_wrap;

  int checks = 0, fails = 0, abort_cnt = 0, abort_base = 0, busy_run = 0;
  bit done = 0;
  typedef struct { bit acc; string req; } exp_t;
  exp_t exp_q[$];
  event frame_ev;

  always #2.5 clk = ~clk;

  flash_reset_ctrl #(
    .LOCK_CYCLES(LOCK), .DEF_STATUS(D_STAT), .DEF_WEL(1'b0), .DEF_SUS(1'b0),
    .DEF_RDPARAM(D_RP), .DEF_CMODE(D_CM), .DEF_WRAP(D_WRAP)
  ) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: abort counting and lockout length
  always @(negedge clk) begin
    if (abort_pulse) abort_cnt++;
    if (busy) busy_run++;
    else if (busy_run != 0) begin
      check(busy_run == LOCK, "R8 busy length", busy_run, LOCK);
      busy_run = 0;
    end
  end

  // Scoreboard: compare expected acceptance per frame
  initial forever begin
    exp_t e;
    @(frame_ev);
    e = exp_q.pop_front();
    check((abort_cnt - abort_base) == int'(e.acc), e.req, abort_cnt - abort_base, int'(e.acc));
    abort_base = abort_cnt;
  end

  task automatic send_frame(input logic [15:0] data, input int nbits,
                            input bit acc, input string req);
    cs_n = 1'b0;
    clks(3);
    for (int i = nbits - 1; i >= 0; i--) begin
      si = data[i];
      clks(4);
      sclk = 1'b1;
      clks(4);
      sclk = 1'b0;
    end
    clks(3);
    cs_n = 1'b1;
    clks(10);
    exp_q.push_back('{acc, req});
    @(posedge clk); #1;
    -> frame_ev;
    clks(2);
  endtask

  task automatic do_update(input logic [7:0] s, input logic w, input logic u,
                           input logic [7:0] rp, input logic [7:0] cm, input logic [2:0] wr);
    upd_status = s; upd_wel = w; upd_sus = u; upd_rdparam = rp; upd_cmode = cm; upd_wrap = wr;
    upd_valid = 1'b1;
    clks(1);
    upd_valid = 1'b0;
    clks(1);
  endtask

  task automatic expect_regs(input logic [7:0] s, input logic w, input logic u,
                             input logic [7:0] rp, input logic [7:0] cm, input logic [2:0] wr,
                             input string req);
    check(st_status == s, {req, " status"}, st_status, s);
    check({st_wel, st_sus} == {w, u}, {req, " wel/sus"}, {st_wel, st_sus}, {w, u});
    check(st_rdparam == rp, {req, " rdparam"}, st_rdparam, rp);
    check(st_cmode == cm, {req, " cmode"}, st_cmode, cm);
    check(st_wrap == wr, {req, " wrap"}, st_wrap, wr);
  endtask

  task automatic wait_idle();
    while (busy) clks(1);
    clks(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    clks(3);
    // R1: defaults under reset
    expect_regs(D_STAT, 0, 0, D_RP, D_CM, D_WRAP, "R1 in reset");
    check(!busy && !abort_pulse, "R1 busy/abort", {busy, abort_pulse}, 0);
    rst_n = 1'b1;
    clks(3);
    // R2: update loads
    do_update(8'h1C, 1, 1, 8'h5A, 8'hA5, 3'b010);
    expect_regs(8'h1C, 1, 1, 8'h5A, 8'hA5, 3'b010, "R2 load");
    // R4: lone reset frame
    send_frame(16'h99, 8, 0, "R4 lone 0x99");
    expect_regs(8'h1C, 1, 1, 8'h5A, 8'hA5, 3'b010, "R4 kept");
    // R3: valid pair
    send_frame(16'h66, 8, 0, "R3 enable frame");
    send_frame(16'h99, 8, 1, "R3 accepted pair");
    check(busy == 1'b1, "R3 busy after accept", busy, 1);
    expect_regs(D_STAT, 0, 0, D_RP, D_CM, D_WRAP, "R3 defaults");
    // R9: frames and updates ignored while busy
    send_frame(16'h66, 8, 0, "R9 enable while busy");
    send_frame(16'h99, 8, 0, "R9 reset while busy");
    do_update(8'h33, 1, 0, 8'h11, 8'h22, 3'b001);
    expect_regs(D_STAT, 0, 0, D_RP, D_CM, D_WRAP, "R9 update dropped");
    check(busy == 1'b1, "R9 still busy", busy, 1);
    wait_idle();
    send_frame(16'h99, 8, 0, "R9 arming cleared");
    // R5: other opcode disarms
    do_update(8'h0F, 1, 0, 8'h77, 8'h10, 3'b100);
    send_frame(16'h66, 8, 0, "R5 enable");
    send_frame(16'h05, 8, 0, "R5 other opcode");
    send_frame(16'h99, 8, 0, "R5 reset after other");
    expect_regs(8'h0F, 1, 0, 8'h77, 8'h10, 3'b100, "R5 kept");
    // R6: odd-length frames disarm
    send_frame(16'h66, 8, 0, "R6 enable a");
    send_frame(16'h4C, 7, 0, "R6 seven bits");
    send_frame(16'h99, 8, 0, "R6 reset after 7");
    send_frame(16'h66, 8, 0, "R6 enable b");
    send_frame(16'h9999, 16, 0, "R6 sixteen bits");
    send_frame(16'h99, 8, 0, "R6 reset after 16");
    send_frame(16'h66, 8, 0, "R6 enable c");
    send_frame(16'h0132, 9, 0, "R6 nine bits 0x99 prefix");
    send_frame(16'h99, 8, 0, "R6 reset after 9");
    expect_regs(8'h0F, 1, 0, 8'h77, 8'h10, 3'b100, "R6 kept");
    // R7: clockless CS pulse keeps arming
    send_frame(16'h66, 8, 0, "R7 enable");
    send_frame(16'h00, 0, 0, "R7 empty pulse");
    send_frame(16'h99, 8, 1, "R7 accepted");
    expect_regs(D_STAT, 0, 0, D_RP, D_CM, D_WRAP, "R7 defaults");
    wait_idle();
    // R3: repeated enable stays armed
    do_update(8'hE1, 0, 1, 8'h3C, 8'hC3, 3'b011);
    send_frame(16'h66, 8, 0, "R3 enable 1");
    send_frame(16'h66, 8, 0, "R3 enable 2");
    send_frame(16'h99, 8, 1, "R3 accepted after double enable");
    expect_regs(D_STAT, 0, 0, D_RP, D_CM, D_WRAP, "R3 defaults 2");
    wait_idle();
    // R1: asynchronous reset mid-run
    do_update(8'hAA, 1, 1, 8'h55, 8'h66, 3'b000);
    #1.2 rst_n = 1'b0;
    #0.5;
    expect_regs(D_STAT, 0, 0, D_RP, D_CM, D_WRAP, "R1 async");
    clks(2);
    rst_n = 1'b1;
    clks(4);
    finish_run();
  end
endmodule